// File: doc/BRIEF.md
# Opcode Class Decoder with Instruction Register

This block captures the 8-bit opcode of the instruction being fetched into an instruction register. It then classifies that opcode onto 48 decode lines, one for each instruction class. The decode is built as a NOR-plane array. Each line is pulled low by any programmed input that is active, so a line stays high only when the opcode fits its pattern.

The array sees each register bit in true and complemented form. It also sees two helper terms that flag the memory operand code 110, one in the destination field (bits 5:3) and one in the source field (bits 2:0). With these terms, a line can exclude the memory forms without needing a separate pattern for each register.

The full 48-line vector feeds a downstream timing sequencer. A 46-line copy, without the interrupt enable/disable line and the halt line, feeds ALU and register-file control. The fetch cycle, T-state and phase strobes arrive from outside the block.

Top module: `opDecode`

## Requirements
- R1: The instruction register takes `dataBus` on a rising clock edge only when `opFetch`=1, `tState`=3 and `phase1`=1 all hold at that edge. At every other edge it keeps its value, and the decode outputs do not change.
- R2: Synchronous reset clears the register to 00h and takes priority over a load on the same edge. After reset, every line of `decodeLines` is low.
- R3: Opcode 00h has no line of its own, so all 48 lines are low while it is held.
- R4: Move lines, with d = bits 5:3 and s = bits 2:0:
  - line 0 is 01dddsss with d≠110 and s≠110;
  - line 1 is 01110sss with s≠110;
  - line 2 is 01ddd110 with d≠110;
  - line 47 is 76h only.
- R5: Arithmetic and immediate-load lines:
  - line 13 is 10xxxsss with s≠110;
  - line 14 is 10xxx110;
  - line 15 is 11xxx110;
  - line 3 is 00ddd110 with d≠110;
  - line 4 is 36h.
- R6: Load, store and register-pair lines:
  - line 5 is 00xx0001; line 6 is 0Ah or 1Ah; line 7 is 02h or 12h;
  - line 8 is 3Ah; line 9 is 32h; line 10 is 2Ah; line 11 is 22h; line 12 is EBh;
  - line 16 is 00ddd10x with d≠110; line 17 is 34h or 35h;
  - line 18 is 00xx0011; line 19 is 00xx1011; line 20 is 00xx1001;
  - line 21 is 000xx111; line 22 is 001xx111.
- R7: Branch, stack and I/O lines:
  - line 23 is C3h; line 24 is 11xxx010; line 25 is CDh; line 26 is 11xxx100;
  - line 27 is C9h; line 28 is 11xxx000; line 29 is 11xxx111;
  - line 30 is E9h; line 31 is F9h; line 32 is E3h;
  - line 33 is 11xx0101; line 34 is 11xx0001;
  - line 35 is DBh; line 36 is D3h.
- R8: Extended lines:
  - line 37 is 08h; line 38 is 18h; line 39 is 10h; line 40 is 28h or 38h;
  - line 41 is CBh; line 42 is D9h; line 43 is EDh; line 44 is DDh or FDh.
- R9: Line 45 (interrupt-mask read/write) is 20h or 30h. Line 46 (interrupt disable/enable) is F3h or FBh.
- R10: `ctrlLines` equals lines 45..0 of `decodeLines`. It carries neither line 46 nor line 47.
- R11: For every opcode, at most one decode line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dataBus | input | 8 | Opcode byte from the data bus |
| opFetch | input | 1 | High during the opcode fetch machine cycle |
| tState | input | 3 | Current T-state number |
| phase1 | input | 1 | High in clock phase 1 |
| decodeLines | output | 48 | Instruction-class lines for the timing sequencer |
| ctrlLines | output | 46 | Subset for ALU and register-file control |

## Verification
The checker watches the following on every cycle:
- the register holds whenever the load strobe is incomplete;
- the outputs are quiet after reset and for 00h;
- at most one line is high;
- halt leaves the control subset dark;
- no move line fires when both fields are 110;
- the ALU register line never fires for a 110 source.

Only the bench scenarios can show that each of the 48 patterns matches exactly its opcodes. The bench sweeps all 256 codes, including the 110-field exclusions, and also shows reset winning over a simultaneous load.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  localparam int OPC_W     = 8;
  localparam int NUM_LINES = 48;
  localparam int NUM_CTRL  = 46;
  localparam int PLA_IN_W  = 2 * OPC_W + 2;
  localparam int DST_HELP  = 2 * OPC_W;
  localparam int SRC_HELP  = 2 * OPC_W + 1;

  // Strobes from the control side to the register datapath
  typedef struct packed {
    logic clearIr;
    logic loadIr;
  } irStrobe_t;

  // One decode line: which bits matter, their required values and
  // whether a memory code in the destination or source field inhibits it
  typedef struct packed {
    logic [OPC_W-1:0] care;
    logic [OPC_W-1:0] val;
    logic             inhDst;
    logic             inhSrc;
  } linePat_t;

  function automatic linePat_t linePat(input int idx);
    linePat_t p;
    case (idx)
      0:  p = '{8'hC0, 8'h40, 1'b1, 1'b1}; // reg to reg move
      1:  p = '{8'hF8, 8'h70, 1'b0, 1'b1}; // move to memory
      2:  p = '{8'hC7, 8'h46, 1'b1, 1'b0}; // move from memory
      3:  p = '{8'hC7, 8'h06, 1'b1, 1'b0}; // immediate to register
      4:  p = '{8'hFF, 8'h36, 1'b0, 1'b0}; // immediate to memory
      5:  p = '{8'hCF, 8'h01, 1'b0, 1'b0}; // pair immediate
      6:  p = '{8'hEF, 8'h0A, 1'b0, 1'b0}; // accumulator load indirect
      7:  p = '{8'hEF, 8'h02, 1'b0, 1'b0}; // accumulator store indirect
      8:  p = '{8'hFF, 8'h3A, 1'b0, 1'b0}; // accumulator load direct
      9:  p = '{8'hFF, 8'h32, 1'b0, 1'b0}; // accumulator store direct
      10: p = '{8'hFF, 8'h2A, 1'b0, 1'b0}; // pointer load direct
      11: p = '{8'hFF, 8'h22, 1'b0, 1'b0}; // pointer store direct
      12: p = '{8'hFF, 8'hEB, 1'b0, 1'b0}; // pointer swap
      13: p = '{8'hC0, 8'h80, 1'b0, 1'b1}; // alu register operand
      14: p = '{8'hC7, 8'h86, 1'b0, 1'b0}; // alu memory operand
      15: p = '{8'hC7, 8'hC6, 1'b0, 1'b0}; // alu immediate operand
      16: p = '{8'hC6, 8'h04, 1'b1, 1'b0}; // step register
      17: p = '{8'hFE, 8'h34, 1'b0, 1'b0}; // step memory
      18: p = '{8'hCF, 8'h03, 1'b0, 1'b0}; // pair increment
      19: p = '{8'hCF, 8'h0B, 1'b0, 1'b0}; // pair decrement
      20: p = '{8'hCF, 8'h09, 1'b0, 1'b0}; // pair add
      21: p = '{8'hE7, 8'h07, 1'b0, 1'b0}; // accumulator rotate
      22: p = '{8'hE7, 8'h27, 1'b0, 1'b0}; // accumulator and flag misc
      23: p = '{8'hFF, 8'hC3, 1'b0, 1'b0}; // jump
      24: p = '{8'hC7, 8'hC2, 1'b0, 1'b0}; // conditional jump
      25: p = '{8'hFF, 8'hCD, 1'b0, 1'b0}; // call
      26: p = '{8'hC7, 8'hC4, 1'b0, 1'b0}; // conditional call
      27: p = '{8'hFF, 8'hC9, 1'b0, 1'b0}; // return
      28: p = '{8'hC7, 8'hC0, 1'b0, 1'b0}; // conditional return
      29: p = '{8'hC7, 8'hC7, 1'b0, 1'b0}; // restart vector
      30: p = '{8'hFF, 8'hE9, 1'b0, 1'b0}; // jump via pointer
      31: p = '{8'hFF, 8'hF9, 1'b0, 1'b0}; // pointer to stack
      32: p = '{8'hFF, 8'hE3, 1'b0, 1'b0}; // stack top swap
      33: p = '{8'hCF, 8'hC5, 1'b0, 1'b0}; // push pair
      34: p = '{8'hCF, 8'hC1, 1'b0, 1'b0}; // pop pair
      35: p = '{8'hFF, 8'hDB, 1'b0, 1'b0}; // port input
      36: p = '{8'hFF, 8'hD3, 1'b0, 1'b0}; // port output
      37: p = '{8'hFF, 8'h08, 1'b0, 1'b0}; // pair subtract
      38: p = '{8'hFF, 8'h18, 1'b0, 1'b0}; // pair rotate
      39: p = '{8'hFF, 8'h10, 1'b0, 1'b0}; // pointer shift
      40: p = '{8'hEF, 8'h28, 1'b0, 1'b0}; // offset address
      41: p = '{8'hFF, 8'hCB, 1'b0, 1'b0}; // overflow trap
      42: p = '{8'hFF, 8'hD9, 1'b0, 1'b0}; // pointer store indexed
      43: p = '{8'hFF, 8'hED, 1'b0, 1'b0}; // pointer load indexed
      44: p = '{8'hDF, 8'hDD, 1'b0, 1'b0}; // jump on flag K
      45: p = '{8'hEF, 8'h20, 1'b0, 1'b0}; // interrupt mask access
      46: p = '{8'hF7, 8'hF3, 1'b0, 1'b0}; // interrupt disable/enable
      47: p = '{8'hFF, 8'h76, 1'b0, 1'b0}; // halt
      default: p = '{8'h00, 8'h00, 1'b1, 1'b1};
    endcase
    return p;
  endfunction

  // Array input layout: [7:0] true bits, [15:8] complements,
  // [16] destination-memory helper, [17] source-memory helper
  function automatic logic [PLA_IN_W-1:0] pullMask(input linePat_t p);
    logic [PLA_IN_W-1:0] m;
    m = '0;
    for (int b = 0; b < OPC_W; b++) begin
      if (p.care[b]) begin
        if (p.val[b]) m[OPC_W + b] = 1'b1;
        else          m[b]         = 1'b1;
      end
    end
    m[DST_HELP] = p.inhDst;
    m[SRC_HELP] = p.inhSrc;
    return m;
  endfunction

endpackage

// File: rtl/op_ir_ctrl.sv
module opIrCtrl
  import opdec_pkg::*;
#(
  parameter int TSTATE_W = 3,
  parameter int LOAD_T   = 3
) (
  input  logic                rst,
  input  logic                opFetch,
  input  logic [TSTATE_W-1:0] tState,
  input  logic                phase1,
  output irStrobe_t           strb
);

  logic loadPoint;

  assign loadPoint = opFetch && (tState == TSTATE_W'(LOAD_T)) && phase1;

  always_comb begin
    strb.clearIr = rst;
    strb.loadIr  = loadPoint && !rst;
  end

endmodule

// File: rtl/op_ir_path.sv
module opIrPath
  import opdec_pkg::*;
(
  input  logic                clk,
  input  irStrobe_t           strb,
  input  logic [OPC_W-1:0]    dataBus,
  output logic [PLA_IN_W-1:0] plaIn
);

  logic [OPC_W-1:0] irQ;
  logic [OPC_W-1:0] irN;
  logic             dstMem;
  logic             srcMem;

  always_ff @(posedge clk) begin
    if (strb.clearIr)     irQ <= '0;
    else if (strb.loadIr) irQ <= dataBus;
  end

  assign irN = ~irQ;

  // Memory code 110 in a field: NOR of the terms that reject it
  assign dstMem = ~(irN[5] | irN[4] | irQ[3]);
  assign srcMem = ~(irN[2] | irN[1] | irQ[0]);

  assign plaIn = {srcMem, dstMem, irN, irQ};

endmodule

// File: rtl/op_dec_pla.sv
module opDecPla
  import opdec_pkg::*;
#(
  parameter int LINES = NUM_LINES
) (
  input  logic [PLA_IN_W-1:0] plaIn,
  output logic [LINES-1:0]    lines
);

  for (genvar i = 0; i < LINES; i++) begin : gLine
    localparam logic [PLA_IN_W-1:0] PULL = pullMask(linePat(i));
    assign lines[i] = ~|(PULL & plaIn);
  end

endmodule

// File: rtl/op_decode.sv
module opDecode
  import opdec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [OPC_W-1:0]     dataBus,
  input  logic                 opFetch,
  input  logic [2:0]           tState,
  input  logic                 phase1,
  output logic [NUM_LINES-1:0] decodeLines,
  output logic [NUM_CTRL-1:0]  ctrlLines
);

  irStrobe_t           strb;
  logic [PLA_IN_W-1:0] plaIn;

  opIrCtrl #(.TSTATE_W(3), .LOAD_T(3)) uCtrl (
    .rst     (rst),
    .opFetch (opFetch),
    .tState  (tState),
    .phase1  (phase1),
    .strb    (strb)
  );

  opIrPath uPath (
    .clk     (clk),
    .strb    (strb),
    .dataBus (dataBus),
    .plaIn   (plaIn)
  );

  opDecPla #(.LINES(NUM_LINES)) uPla (
    .plaIn (plaIn),
    .lines (decodeLines)
  );

  // Lines 46 and 47 stay with the sequencer only
  assign ctrlLines = decodeLines[NUM_CTRL-1:0];

endmodule

module opDecodeChk
  import opdec_pkg::*;
(
  input logic                 clk,
  input logic                 rst,
  input logic                 opFetch,
  input logic [2:0]           tState,
  input logic                 phase1,
  input logic [OPC_W-1:0]     irQ,
  input logic [NUM_LINES-1:0] decodeLines,
  input logic [NUM_CTRL-1:0]  ctrlLines
);

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(opFetch && tState == 3'd3 && phase1) |=> $stable(decodeLines)); // R1

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> decodeLines == '0); // R2

  AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    irQ == 8'h00 |-> decodeLines == '0); // R3

  AST_MEM_BOTH_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (irQ[5:3] == 3'b110 && irQ[2:0] == 3'b110) |-> decodeLines[2:0] == 3'b000); // R4

  AST_ALU_REG_SRC: assert property (@(posedge clk) disable iff (rst)
    decodeLines[13] |-> irQ[2:0] != 3'b110); // R5

  AST_HALT_NOT_CTRL: assert property (@(posedge clk) disable iff (rst)
    decodeLines[47] |-> ctrlLines == '0); // R10

  AST_ONE_LINE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(decodeLines)); // R11

endmodule

bind opDecode opDecodeChk uChk (
  .clk         (clk),
  .rst         (rst),
  .opFetch     (opFetch),
  .tState      (tState),
  .phase1      (phase1),
  .irQ         (plaIn[7:0]),
  .decodeLines (decodeLines),
  .ctrlLines   (ctrlLines)
);

// File: tb/tb_opDecode.sv
`timescale 1ns/1ps
module tb_opDecode;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  dataBus;
  logic        opFetch;
  logic [2:0]  tState;
  logic        phase1;
  logic [47:0] decodeLines;
  logic [45:0] ctrlLines;

  always #2 clk = ~clk;

  opDecode dut (
    .clk         (clk),
    .rst         (rst),
    .dataBus     (dataBus),
    .opFetch     (opFetch),
    .tState      (tState),
    .phase1      (phase1),
    .decodeLines (decodeLines),
    .ctrlLines   (ctrlLines)
  );

  int   compared   = 0;
  int   mismatched = 0;
  bit   finished   = 0;
  bit   modelOn    = 0;
  logic [7:0] modelIr;

  // Expected lines from the opcode classes in the requirements
  function automatic logic [47:0] refDecode(input logic [7:0] op);
    logic [47:0] r;
    logic [1:0]  hi;
    logic [2:0]  d;
    logic [2:0]  s;
    hi = op[7:6];
    d  = op[5:3];
    s  = op[2:0];
    r  = '0;
    r[0]  = hi == 2'd1 && d != 3'd6 && s != 3'd6;
    r[1]  = hi == 2'd1 && d == 3'd6 && s != 3'd6;
    r[2]  = hi == 2'd1 && s == 3'd6 && d != 3'd6;
    r[3]  = hi == 2'd0 && s == 3'd6 && d != 3'd6;
    r[4]  = op == 8'h36;
    r[5]  = hi == 2'd0 && op[3:0] == 4'h1;
    r[6]  = op == 8'h0A || op == 8'h1A;
    r[7]  = op == 8'h02 || op == 8'h12;
    r[8]  = op == 8'h3A;
    r[9]  = op == 8'h32;
    r[10] = op == 8'h2A;
    r[11] = op == 8'h22;
    r[12] = op == 8'hEB;
    r[13] = hi == 2'd2 && s != 3'd6;
    r[14] = hi == 2'd2 && s == 3'd6;
    r[15] = hi == 2'd3 && s == 3'd6;
    r[16] = hi == 2'd0 && (s == 3'd4 || s == 3'd5) && d != 3'd6;
    r[17] = op == 8'h34 || op == 8'h35;
    r[18] = hi == 2'd0 && op[3:0] == 4'h3;
    r[19] = hi == 2'd0 && op[3:0] == 4'hB;
    r[20] = hi == 2'd0 && op[3:0] == 4'h9;
    r[21] = hi == 2'd0 && s == 3'd7 && d < 3'd4;
    r[22] = hi == 2'd0 && s == 3'd7 && d >= 3'd4;
    r[23] = op == 8'hC3;
    r[24] = hi == 2'd3 && s == 3'd2;
    r[25] = op == 8'hCD;
    r[26] = hi == 2'd3 && s == 3'd4;
    r[27] = op == 8'hC9;
    r[28] = hi == 2'd3 && s == 3'd0;
    r[29] = hi == 2'd3 && s == 3'd7;
    r[30] = op == 8'hE9;
    r[31] = op == 8'hF9;
    r[32] = op == 8'hE3;
    r[33] = hi == 2'd3 && op[3:0] == 4'h5;
    r[34] = hi == 2'd3 && op[3:0] == 4'h1;
    r[35] = op == 8'hDB;
    r[36] = op == 8'hD3;
    r[37] = op == 8'h08;
    r[38] = op == 8'h18;
    r[39] = op == 8'h10;
    r[40] = op == 8'h28 || op == 8'h38;
    r[41] = op == 8'hCB;
    r[42] = op == 8'hD9;
    r[43] = op == 8'hED;
    r[44] = op == 8'hDD || op == 8'hFD;
    r[45] = op == 8'h20 || op == 8'h30;
    r[46] = op == 8'hF3 || op == 8'hFB;
    r[47] = op == 8'h76;
    return r;
  endfunction

  function automatic string reqOfLine(input int idx);
    if (idx <= 2 || idx == 47)                        return "R4";
    if (idx == 3 || idx == 4 || (idx >= 13 && idx <= 15)) return "R5";
    if (idx <= 22)                                    return "R6";
    if (idx <= 36)                                    return "R7";
    if (idx <= 44)                                    return "R8";
    return "R9";
  endfunction

  function automatic int firstDiff(input logic [47:0] a, input logic [47:0] b);
    for (int i = 0; i < 48; i++) if (a[i] !== b[i]) return i;
    return 0;
  endfunction

  // Behavioural register model: load at the fetch/T3/phase-1 point, reset wins
  always @(posedge clk) begin
    if (rst)                                          modelIr <= 8'h00;
    else if (opFetch && tState == 3'd3 && phase1)     modelIr <= dataBus;
    modelOn <= 1'b1;
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (modelOn && !finished) begin
      logic [47:0] e;
      e = refDecode(modelIr);
      compared++;
      if (decodeLines !== e) begin
        mismatched++;
        $display("FAIL %s line %0d: opcode %h actual %h expected %h",
                 reqOfLine(firstDiff(decodeLines, e)), firstDiff(decodeLines, e),
                 modelIr, decodeLines, e);
      end
      compared++;
      if (ctrlLines !== e[45:0]) begin
        mismatched++;
        $display("FAIL R10 subset: actual %h expected %h", ctrlLines, e[45:0]);
      end
      compared++;
      if ($countones(decodeLines) > 1) begin
        mismatched++;
        $display("FAIL R11 lines high: actual %0d expected <=1", $countones(decodeLines));
      end
    end
  end

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] d, input logic f, input logic [2:0] t, input logic p);
    @(negedge clk);
    dataBus = d;
    opFetch = f;
    tState  = t;
    phase1  = p;
  endtask

  task automatic finishRun();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog (R1..R11 incomplete): actual timeout expected finish");
      finishRun();
    end
  end

  initial begin
    rst = 1'b1; dataBus = 8'h00; opFetch = 1'b0; tState = 3'd0; phase1 = 1'b0;
    repeat (3) drive(8'hC3, 1'b0, 3'd3, 1'b1);
    check("R2", decodeLines, 48'h0);
    rst = 1'b0;

    // R3: a load of 00h keeps every line low
    drive(8'h00, 1'b1, 3'd3, 1'b1);
    drive(8'h5A, 1'b0, 3'd0, 1'b0);
    check("R3", decodeLines, 48'h0);

    // Sweep all opcodes through the load point, then hold with partial strobes
    for (int op = 0; op < 256; op++) begin
      logic [47:0] e;
      e = refDecode(8'(op));
      drive(8'(op), 1'b1, 3'd3, 1'b1);
      drive(~8'(op), 1'b1, 3'd3, 1'b0);
      check(reqOfLine(firstDiff(decodeLines, e)), decodeLines, e);
      drive(8'(op) ^ 8'h55, 1'b0, 3'd3, 1'b1);
      drive(8'(op + 1), 1'b1, 3'd2, 1'b1);
      drive(8'hA5, 1'b0, 3'd0, 1'b0);
      check("R1", decodeLines, e);
      check("R10", {2'b00, ctrlLines}, {2'b00, e[45:0]});
    end

    // Memory-field corner cases, explicit
    drive(8'h76, 1'b1, 3'd3, 1'b1);
    drive(8'h00, 1'b0, 3'd0, 1'b0);
    check("R4", decodeLines, 48'h1 << 47);
    check("R10", {2'b00, ctrlLines}, 48'h0);
    drive(8'hF3, 1'b1, 3'd3, 1'b1);
    drive(8'h00, 1'b0, 3'd0, 1'b0);
    check("R9", decodeLines, 48'h1 << 46);
    drive(8'h30, 1'b1, 3'd3, 1'b1);
    drive(8'h00, 1'b0, 3'd0, 1'b0);
    check("R9", decodeLines, 48'h1 << 45);
    drive(8'h86, 1'b1, 3'd3, 1'b1);
    drive(8'h00, 1'b0, 3'd0, 1'b0);
    check("R5", decodeLines, 48'h1 << 14);
    drive(8'h34, 1'b1, 3'd3, 1'b1);
    drive(8'h00, 1'b0, 3'd0, 1'b0);
    check("R6", decodeLines, 48'h1 << 17);

    // Reset beats a simultaneous load
    drive(8'hC3, 1'b1, 3'd3, 1'b1);
    drive(8'hC3, 1'b1, 3'd3, 1'b1);
    rst = 1'b1;
    drive(8'hCD, 1'b0, 3'd0, 1'b0);
    check("R2", decodeLines, 48'h0);
    rst = 1'b0;
    drive(8'h00, 1'b0, 3'd0, 1'b0);
    drive(8'h00, 1'b0, 3'd0, 1'b0);
    finishRun();
  end

endmodule